// File: doc/BRIEF.md
# Halfword Shifter with Signed Count and Status Flags

This block shifts one 16-bit half of a 32-bit source word and writes the result into one half of a 32-bit destination register. Which source half feeds the shifter and which destination half receives the result are chosen independently. The half that is not written keeps its old contents.

A single signed count sets both the direction and the distance of the shift. Only the low six bits of the count input are used. A mode input picks arithmetic or logical filling for right shifts.

Each accepted operation also updates a set of status flags: zero, negative, carry and two overflow bits. A one-cycle strobe marks an operation. The destination half and the flags are registered together on the clock edge where the strobe is high.

Top module: `hshift_unit`

## Requirements
- R1: A synchronous reset clears the whole destination word and all five flags to zero.
- R2: Only bits [5:0] of the count input are used, read as two's complement from -32 to +31. The upper bits have no effect, so a raw count of 63 acts as -1.
- R3: A positive count shifts the operand left by that many places, filling with zeros. A count of zero passes the operand through unchanged.
- R4: With arith_mode=1, a negative count shifts right by its magnitude and fills with copies of operand bit 15. A magnitude of 16 or more gives all copies of the sign bit. For example, 0x8000 shifted by -4 gives 0xF800.
- R5: With arith_mode=0, a negative count shifts right by its magnitude and fills with zeros. A magnitude of 16 or more gives zero. For example, 0x8000 shifted by -4 gives 0x0800.
- R6: A left shift by 16 through 31 places gives 0x0000.
- R7: src_hi=1 selects src_word[31:16] as the operand, and src_hi=0 selects src_word[15:0].
- R8: dst_hi=1 writes the result into dst_word[31:16], and dst_hi=0 writes it into dst_word[15:0]. The other half keeps its previous value.
- R9: After an operation, flag_zero is 1 exactly when the 16-bit result is 0x0000.
- R10: After an operation, flag_neg equals bit 15 of the result.
- R11: After every operation, flag_carry, flag_ovf0 and flag_ovf1 read 0. This includes left shifts that push set bits out.
- R12: While op_valid is 0, dst_word and all flags hold their values.
- R13: The result and the flags appear on the outputs after the first rising clock edge at which op_valid is 1. They do not appear before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe |
| src_word | input | 32 | Source word holding both candidate operands |
| src_hi | input | 1 | Operand half select (1 = upper) |
| dst_hi | input | 1 | Destination half select (1 = upper) |
| arith_mode | input | 1 | 1 = arithmetic right fill, 0 = logical |
| count_in | input | 16 | Shift count; bits [5:0] used as a signed value |
| dst_word | output | 32 | Destination register |
| flag_zero | output | 1 | Result was zero |
| flag_neg | output | 1 | Result bit 15 |
| flag_carry | output | 1 | Carry flag, always cleared by an operation |
| flag_ovf0 | output | 1 | First overflow flag, always cleared by an operation |
| flag_ovf1 | output | 1 | Second overflow flag, always cleared by an operation |

## Verification
The assertions check on every cycle that:
- an idle strobe leaves the register and the flags untouched;
- the unwritten destination half survives an operation;
- zero and negative agree with the half just written;
- carry and overflow read clear after an operation;
- a zero count copies the selected operand straight through.

The shift values themselves can only be shown by the bench's scenarios. These cover left versus right, sign versus zero fill, the wrap of large counts, and the saturation to zero or sign at distances of 16 and beyond. The bench sweeps all 64 count codes over several operands, both modes and all four half pairings.

// File: rtl/hshift_unit.sv
module hshift_unit #(
  parameter int HW   = 16,
  parameter int CNTW = 16,
  parameter int SHW  = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [2*HW-1:0] src_word,
  input  logic            src_hi,
  input  logic            dst_hi,
  input  logic            arith_mode,
  input  logic [CNTW-1:0] count_in,
  output logic [2*HW-1:0] dst_word,
  output logic            flag_zero,
  output logic            flag_neg,
  output logic            flag_carry,
  output logic            flag_ovf0,
  output logic            flag_ovf1
);
  localparam int WW = 2 * HW;

  logic [HW-1:0]  opnd;
  logic [SHW-1:0] amt;
  logic           go_right;
  logic [SHW-1:0] mag;
  logic           fill;
  logic [HW-1:0]  res;
  logic [WW-1:0]  ext;

  assign opnd     = src_hi ? src_word[WW-1:HW] : src_word[HW-1:0];
  assign amt      = count_in[SHW-1:0];
  assign go_right = amt[SHW-1];
  assign mag      = go_right ? (~amt + 1'b1) : amt;
  assign fill     = arith_mode & opnd[HW-1];
  assign ext      = {{HW{fill}}, opnd} >> mag;

  always_comb begin
    if (mag >= SHW'(HW))
      res = go_right ? {HW{fill}} : '0;
    else if (go_right)
      res = ext[HW-1:0];
    else
      res = opnd << mag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_word   <= '0;
      flag_zero  <= 1'b0;
      flag_neg   <= 1'b0;
      flag_carry <= 1'b0;
      flag_ovf0  <= 1'b0;
      flag_ovf1  <= 1'b0;
    end else if (op_valid) begin
      if (dst_hi) dst_word[WW-1:HW] <= res;
      else        dst_word[HW-1:0]  <= res;
      flag_zero  <= (res == '0);
      flag_neg   <= res[HW-1];
      flag_carry <= 1'b0;
      flag_ovf0  <= 1'b0;
      flag_ovf1  <= 1'b0;
    end
  end
endmodule

// File: rtl/hshift_unit_chk.sv
module hshift_unit_chk #(
  parameter int HW   = 16,
  parameter int CNTW = 16,
  parameter int SHW  = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            op_valid,
  input logic [2*HW-1:0] src_word,
  input logic            src_hi,
  input logic            dst_hi,
  input logic            arith_mode,
  input logic [CNTW-1:0] count_in,
  input logic [2*HW-1:0] dst_word,
  input logic            flag_zero,
  input logic            flag_neg,
  input logic            flag_carry,
  input logic            flag_ovf0,
  input logic            flag_ovf1
);
  localparam int WW = 2 * HW;

  p_hold_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(dst_word) && $stable(flag_zero) && $stable(flag_neg)
                  && $stable(flag_carry) && $stable(flag_ovf0) && $stable(flag_ovf1));

  p_keep_other_r8: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> ($past(dst_hi) ? (dst_word[HW-1:0] == $past(dst_word[HW-1:0]))
                                : (dst_word[WW-1:HW] == $past(dst_word[WW-1:HW]))));

  p_zero_flag_r9: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> flag_zero == (($past(dst_hi) ? dst_word[WW-1:HW] : dst_word[HW-1:0]) == '0));

  p_neg_flag_r10: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> flag_neg == ($past(dst_hi) ? dst_word[WW-1] : dst_word[HW-1]));

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> !flag_carry && !flag_ovf0 && !flag_ovf1);

  p_pass_zero_r3: assert property (@(posedge clk) disable iff (rst)
    op_valid && (count_in[SHW-1:0] == '0) |=>
      (($past(dst_hi) ? dst_word[WW-1:HW] : dst_word[HW-1:0]) ==
       ($past(src_hi) ? $past(src_word[WW-1:HW]) : $past(src_word[HW-1:0]))));
endmodule

bind hshift_unit hshift_unit_chk #(.HW(HW), .CNTW(CNTW), .SHW(SHW)) u_chk (.*);

// File: tb/hshift_unit_bench.sv
module hshift_unit_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [31:0] src_word = '0;
  logic        src_hi = 1'b0;
  logic        dst_hi = 1'b0;
  logic        arith_mode = 1'b0;
  logic [15:0] count_in = '0;
  logic [31:0] dst_word;
  logic        flag_zero, flag_neg, flag_carry, flag_ovf0, flag_ovf1;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] model = '0;

  always #(CLK_P/2) clk = ~clk;

  hshift_unit u_hshift_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .src_word(src_word),
    .src_hi(src_hi), .dst_hi(dst_hi), .arith_mode(arith_mode), .count_in(count_in),
    .dst_word(dst_word), .flag_zero(flag_zero), .flag_neg(flag_neg),
    .flag_carry(flag_carry), .flag_ovf0(flag_ovf0), .flag_ovf1(flag_ovf1)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int expect_shift(input int op, input int c, input bit ar);
    int s, p, m;
    if (c >= 0) begin
      if (c >= 16) return 0;
      return (op * (1 << c)) % 65536;
    end
    m = -c;
    if (!ar) return (m >= 16) ? 0 : op / (1 << m);
    s = (op >= 32768) ? op - 65536 : op;
    if (m >= 16) return (s < 0) ? 65535 : 0;
    p = 1 << m;
    if (s < 0) s = (s - (p - 1)) / p;
    else       s = s / p;
    return s & 65535;
  endfunction

  task automatic run_op(input int op, input int raw, input bit ar, input bit sh, input bit dh);
    int c6, c, r;
    string tag;
    c6 = raw % 64;
    c  = (c6 >= 32) ? c6 - 64 : c6;
    r  = expect_shift(op, c, ar);
    if (c >= 16)      tag = "R6";
    else if (c >= 0)  tag = "R3";
    else if (ar)      tag = "R4";
    else              tag = "R5";
    if (raw >= 32) tag = {tag, " R2"};
    @(negedge clk);
    src_word   = sh ? {op[15:0], 16'h5A3C ^ op[15:0]} : {16'hC3A5 ^ op[15:0], op[15:0]};
    src_hi     = sh;
    dst_hi     = dh;
    arith_mode = ar;
    count_in   = {10'(raw * 37 + 5), 6'(c6)};
    op_valid   = 1'b1;
    @(negedge clk);
    op_valid   = 1'b0;
    if (dh) model[31:16] = r[15:0];
    else    model[15:0]  = r[15:0];
    check(dst_word == model, {tag, " R7 R8"}, dst_word, model);
    check(flag_zero == (r == 0) && flag_neg == r[15], "R9 R10",
          {flag_zero, flag_neg}, {r == 0, r[15]});
    check({flag_carry, flag_ovf0, flag_ovf1} == 3'b000, "R11",
          {flag_carry, flag_ovf0, flag_ovf1}, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int ops[7] = '{32'h0001, 32'h8000, 32'hFFFF, 32'h0100, 32'h0000, 32'h7FFF, 32'hA5C3};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(dst_word == 0 && {flag_zero, flag_neg, flag_carry, flag_ovf0, flag_ovf1} == 0,
          "R1", dst_word, 0);

    run_op(32'h8000, 60, 1'b1, 1'b0, 1'b0);
    check(dst_word[15:0] == 16'hF800, "R4", dst_word[15:0], 16'hF800);
    run_op(32'h8000, 60, 1'b0, 1'b0, 1'b0);
    check(dst_word[15:0] == 16'h0800, "R5", dst_word[15:0], 16'h0800);
    run_op(32'h0100, 63, 1'b0, 1'b0, 1'b1);
    check(dst_word[31:16] == 16'h0080, "R2", dst_word[31:16], 16'h0080);

    for (int op_i = 0; op_i < 7; op_i++)
      for (int raw = 0; raw < 64; raw++)
        for (int mode = 0; mode < 4; mode++)
          run_op(ops[op_i], raw, mode[0], mode[1], mode[0] ^ mode[1] ^ raw[0]);

    // R13: result not visible before the capturing edge
    @(negedge clk);
    src_word = 32'h0000_0003; src_hi = 1'b0; dst_hi = 1'b0;
    arith_mode = 1'b0; count_in = 16'd2; op_valid = 1'b1;
    #(CLK_P/4);
    check(dst_word == model, "R13", dst_word, model);
    @(negedge clk);
    op_valid = 1'b0;
    model[15:0] = 16'h000C;
    check(dst_word == model, "R13", dst_word, model);

    // R12: idle strobe leaves state alone
    @(negedge clk);
    src_word = 32'hFFFF_FFFF; count_in = 16'd1; arith_mode = 1'b1;
    repeat (3) @(negedge clk);
    check(dst_word == model && !flag_zero && !flag_neg, "R12", dst_word, model);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(dst_word == 0 && {flag_zero, flag_neg} == 0, "R1", dst_word, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule